// File: doc/BRIEF.md
# Banked Transpose Slice Writer

This block accepts one wide input beat per handshake and stores it in transposed form. The beat is cut into a fixed number of equal channel slices. Element `j` of every slice is then grouped with element `j` of all the other slices, so channel-major data is stored in spatial-major order. The regrouped beat is written in a single cycle into a grid of byte-wide memories. The grid has one bank for each element index, and each bank holds one memory for each slice index.

Every byte has a fixed home in the grid, so the write side needs no crossbar and no multiplexer. All memories share one write address, and that address counts accepted beats. When a programmed number of beats has been stored, a one-cycle completion pulse is raised. The running beat count is reported to the consumer on the read side. That consumer fetches bytes through a simple registered port that selects bank, instance and address.

Top module: `tsw_writer`

## Requirements
- R1: After reset, `in_ready` is 1, `done` is 0, `beats_written` is 0 and `rd_byte` is 0.
- R2: A beat is accepted only on a rising clock edge where `in_valid` and `in_ready` are both 1. Each accepted beat raises `beats_written` by exactly one. Without an accept, `beats_written` holds its value.
- R3: Input bytes are numbered from the least significant end: byte `k` is `in_data[8k+7:8k]`. With slice width `S = BUS_BYTES/LANES`, byte `i*S+j` of a beat is stored in bank `j`, instance `i`, at the address equal to the value `beats_written` had before that beat was accepted.
- R4: A single accepted beat stores all `BUS_BYTES` bytes in the same cycle, one byte in every memory of every bank.
- R5: While `beats_written` equals `DEPTH`, `in_ready` is 0. Any `in_valid` in that state is ignored: the count holds and no stored byte changes. `in_ready` falls in the cycle after the accept that fills the last address.
- R6: `done` is high for exactly one cycle, in the cycle after the accept that brings `beats_written` to `beat_target`. If `beat_target` is 0, `done` never goes high.
- R7: The read port returns on `rd_byte` the byte stored at (`rd_bank`, `rd_inst`, `rd_addr`), one clock after those inputs are presented.
- R8: Changing `in_data` while `in_valid` is 0 alters no stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_data | input | BUS_BYTES*8 | Input beat, byte 0 in the low bits |
| beat_target | input | CW | Beat count that triggers `done` |
| done | output | 1 | One-cycle completion pulse |
| beats_written | output | CW | Beats stored so far |
| rd_bank | input | BW | Read bank (element index) |
| rd_inst | input | IW | Read instance (slice index) |
| rd_addr | input | AW | Read address (beat number) |
| rd_byte | output | 8 | Registered read data |

## Verification
Two events can land in the same cycle: the completion pulse and the drop of `in_ready` when the memories fill. The bench makes them coincide by programming `beat_target` equal to `DEPTH` and streaming a full set of beats. On the sample after the last accept, it expects `done` high and `in_ready` low together. It then holds `in_valid` high with fresh data and confirms that the count stays put. A full read-back then shows that address 0 was not overwritten by a wrapped write address.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

  // Width needed to index n items, never less than one bit.
  function automatic int idx_width(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // Input byte position of element j in slice i, for a slice width s.
  function automatic int src_byte(input int i, input int j, input int s);
    return i * s + j;
  endfunction

  // Flat slot of bank j, instance i, in bank-major order.
  function automatic int home_slot(input int j, input int i, input int lanes);
    return j * lanes + i;
  endfunction

endpackage

// File: rtl/tsw_slicer.sv
module tsw_slicer
  import tsw_pkg::*;
#(
  parameter int BUS_BYTES = 16,
  parameter int LANES     = 4
) (
  input  logic [BUS_BYTES*8-1:0] beat_in,
  output logic [BUS_BYTES*8-1:0] grp_out
);
  localparam int S = BUS_BYTES / LANES;

  initial begin
    if (BUS_BYTES % LANES != 0)
      $error("BUS_BYTES must be a multiple of LANES");
  end

  // Fixed wiring: each byte goes to its home slot.
  for (genvar j = 0; j < S; j++) begin : g_bank
    for (genvar i = 0; i < LANES; i++) begin : g_inst
      assign grp_out[home_slot(j, i, LANES)*8 +: 8] = beat_in[src_byte(i, j, S)*8 +: 8];
    end
  end

endmodule

// File: rtl/tsw_bytemem.sv
module tsw_bytemem #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];

endmodule

// File: rtl/tsw_addr_ctrl.sv
module tsw_addr_ctrl #(
  parameter int DEPTH = 16,
  parameter int CW    = 5,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CW-1:0] beat_target,
  output logic          in_ready,
  output logic          accept,
  output logic [AW-1:0] waddr,
  output logic [CW-1:0] count,
  output logic          done
);
  logic          full;
  logic [CW:0]   count_inc;

  assign full      = (count == CW'(DEPTH));
  assign in_ready  = !full;
  assign accept    = in_valid && in_ready;
  assign waddr     = count[AW-1:0];
  assign count_inc = {1'b0, count} + (CW+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      done  <= 1'b0;
    end else begin
      done <= accept && (count_inc == {1'b0, beat_target});
      if (accept) count <= count_inc[CW-1:0];
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> count == $past(count) + CW'(1)); // R2
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(count)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R5
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(accept)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done ##1 $stable(beat_target) |-> !done); // R6

endmodule

// File: rtl/tsw_writer.sv
module tsw_writer
  import tsw_pkg::*;
#(
  parameter int BUS_BYTES = 16,
  parameter int LANES     = 4,
  parameter int DEPTH     = 16,
  localparam int S        = BUS_BYTES / LANES,
  localparam int CW       = idx_width(DEPTH + 1),
  localparam int AW       = idx_width(DEPTH),
  localparam int BW       = idx_width(S),
  localparam int IW       = idx_width(LANES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [BUS_BYTES*8-1:0] in_data,
  input  logic [CW-1:0]          beat_target,
  output logic                   done,
  output logic [CW-1:0]          beats_written,
  input  logic [BW-1:0]          rd_bank,
  input  logic [IW-1:0]          rd_inst,
  input  logic [AW-1:0]          rd_addr,
  output logic [7:0]             rd_byte
);
  localparam int NMEM = S * LANES;

  logic                   accept;
  logic [AW-1:0]          waddr;
  logic [BUS_BYTES*8-1:0] grp_data;
  logic [7:0]             mem_q [NMEM];

  tsw_addr_ctrl #(.DEPTH(DEPTH), .CW(CW), .AW(AW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .beat_target (beat_target),
    .in_ready    (in_ready),
    .accept      (accept),
    .waddr       (waddr),
    .count       (beats_written),
    .done        (done)
  );

  tsw_slicer #(.BUS_BYTES(BUS_BYTES), .LANES(LANES)) u_slice (
    .beat_in (in_data),
    .grp_out (grp_data)
  );

  // One write enable for the whole grid: every memory is written together.
  for (genvar j = 0; j < S; j++) begin : g_bank
    for (genvar i = 0; i < LANES; i++) begin : g_inst
      tsw_bytemem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (accept),
        .waddr (waddr),
        .wdata (grp_data[home_slot(j, i, LANES)*8 +: 8]),
        .raddr (rd_addr),
        .rdata (mem_q[home_slot(j, i, LANES)])
      );
    end
  end

  // Read-side selection, registered.
  logic [31:0] rd_slot;
  assign rd_slot = 32'(rd_bank) * 32'(LANES) + 32'(rd_inst);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_byte <= 8'h00;
    else if (rd_slot < 32'(NMEM)) rd_byte <= mem_q[rd_slot[idx_width(NMEM)-1:0]];
    else rd_byte <= 8'h00;
  end

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    accept && beats_written == CW'(DEPTH - 1) |=> !in_ready); // R5
  AST_FULL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(beats_written)); // R5
  AST_DONE_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !done); // R6

endmodule

// File: tb/sim_tsw_writer.sv
module sim_tsw_writer;
  localparam int BUS_BYTES = 16;
  localparam int LANES     = 4;
  localparam int DEPTH     = 16;
  localparam int S         = BUS_BYTES / LANES;
  localparam int CW        = $clog2(DEPTH + 1);
  localparam int AW        = $clog2(DEPTH);
  localparam int BW        = $clog2(S);
  localparam int IW        = $clog2(LANES);

  typedef struct {
    int bank;
    int inst;
    int addr;
    logic [7:0] val;
  } item_t;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   in_valid = 1'b0;
  logic                   in_ready;
  logic [BUS_BYTES*8-1:0] in_data = '0;
  logic [CW-1:0]          beat_target = '0;
  logic                   done;
  logic [CW-1:0]          beats_written;
  logic [BW-1:0]          rd_bank = '0;
  logic [IW-1:0]          rd_inst = '0;
  logic [AW-1:0]          rd_addr = '0;
  logic [7:0]             rd_byte;

  int n_checks = 0;
  int n_fail   = 0;
  int model_cnt = 0;
  item_t sb [$];

  always #4 clk = ~clk;

  tsw_writer #(.BUS_BYTES(BUS_BYTES), .LANES(LANES), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .beat_target(beat_target), .done(done),
    .beats_written(beats_written), .rd_bank(rd_bank), .rd_inst(rd_inst),
    .rd_addr(rd_addr), .rd_byte(rd_byte)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input int target);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    beat_target = CW'(target);
    model_cnt = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [BUS_BYTES*8-1:0] make_beat(input int seed);
    logic [BUS_BYTES*8-1:0] b;
    for (int k = 0; k < BUS_BYTES; k++) b[k*8 +: 8] = 8'((seed * 37 + k * 11 + 5) ^ (k << 4));
    return b;
  endfunction

  // Driver: one beat, expected placements pushed into the scoreboard.
  task automatic send_beat(input int seed);
    logic [BUS_BYTES*8-1:0] b;
    b = make_beat(seed);
    in_data = b;
    in_valid = 1'b1;
    for (int i = 0; i < LANES; i++)
      for (int j = 0; j < S; j++)
        sb.push_back('{bank: j, inst: i, addr: model_cnt, val: b[(i*S + j)*8 +: 8]});
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    model_cnt++;
    check("R2 count after accept", 32'(beats_written), 32'(model_cnt));
    check("R6 done after accept", 32'(done), 32'(model_cnt == int'(beat_target) && beat_target != 0));
  endtask

  // Monitor: pop expected items and compare what the read port returns.
  task automatic drain();
    item_t it;
    while (sb.size() > 0) begin
      it = sb.pop_front();
      rd_bank = BW'(it.bank);
      rd_inst = IW'(it.inst);
      rd_addr = AW'(it.addr);
      @(posedge clk);
      @(negedge clk);
      check("R3 R4 R7 R8 stored byte", 32'(rd_byte), 32'(it.val));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    do_reset(5);
    @(negedge clk);
    check("R1 ready after reset", 32'(in_ready), 32'd1);
    check("R1 done after reset", 32'(done), 32'd0);
    check("R1 count after reset", 32'(beats_written), 32'd0);
    check("R1 rd_byte after reset", 32'(rd_byte), 32'd0);

    // Phase A: target 5, idle gaps with changing data (R8, R2 hold).
    for (int n = 0; n < 5; n++) begin
      send_beat(n + 1);
      in_data = make_beat(100 + n);
      @(negedge clk);
      check("R2 count holds without valid", 32'(beats_written), 32'(model_cnt));
      check("R6 done is single cycle", 32'(done), 32'd0);
    end
    drain();

    // Phase B: target equals DEPTH, done and ready drop coincide.
    do_reset(DEPTH);
    for (int n = 0; n < DEPTH; n++) send_beat(200 + n);
    check("R5 ready low when full", 32'(in_ready), 32'd0);
    in_valid = 1'b1;
    for (int n = 0; n < 3; n++) begin
      in_data = make_beat(300 + n);
      @(negedge clk);
      check("R5 count holds when full", 32'(beats_written), 32'(DEPTH));
      check("R5 ready stays low", 32'(in_ready), 32'd0);
      check("R6 no repeat done", 32'(done), 32'd0);
    end
    in_valid = 1'b0;
    drain();

    // Phase C: target 0 never pulses done.
    do_reset(0);
    for (int n = 0; n < 3; n++) send_beat(400 + n);
    @(negedge clk);
    check("R6 no done with target 0", 32'(done), 32'd0);
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule